// File: doc/BRIEF.md
# Linear address tag masking unit

This block sits in front of address translation and strips software metadata from 64-bit data pointers. For every pointer it decides whether tag masking applies and, if it does, which metadata field is ignored. It then applies the canonicality rule for that case, rebuilds the address without the metadata, and raises a fault flag when the rule is broken. Downstream logic therefore only ever sees an untagged address, and any fault it reports carries that same untagged address.

Address bit 63 alone marks a pointer as user (0) or supervisor (1). User pointers take their mode from two user control bits, a wide-tag enable and a narrow-tag enable. Supervisor pointers take theirs from one supervisor enable and the paging depth. Instruction fetches and control-register or model-register writes skip masking and use the ordinary canonicality rule. The unit is a single registered stage with a valid/ready handshake on each side.

Top module: `addr_untag_stage`

## Requirements
- R1: For a data pointer with bit 63 = 0: `in_u_narrow`=1 selects the 6-bit tag field (bits 62:57) whatever `in_u_wide` holds. `in_u_narrow`=0 with `in_u_wide`=1 selects the 15-bit tag field (bits 62:48). Both 0 means no masking.
- R2: For a data pointer with bit 63 = 1: `in_s_en`=0 means no masking. `in_s_en`=1 selects the 6-bit field when `in_five_lvl`=1 and the 15-bit field when `in_five_lvl`=0.
- R3: The user/supervisor split depends only on address bit 63. An unmasked data pointer gets the ordinary rule: bits 63:47 all equal with `in_five_lvl`=0, bits 63:56 all equal with `in_five_lvl`=1. The address passes through unchanged.
- R4: In the 15-bit mode, `out_fault`=1 exactly when bit 63 differs from bit 47. This holds for both paging depths, so the usable width stays 48 bits.
- R5: In the 6-bit mode with `in_five_lvl`=1, `out_fault`=1 exactly when bit 63 differs from bit 56.
- R6: In the user 6-bit mode with `in_five_lvl`=0, `out_fault`=1 unless bit 63 and bits 56:47 are all 0.
- R7: With `in_kind` = 1 (fetch) or 2 (control/model-register write), masking never applies. The ordinary rule of R3 decides `out_fault`, and `out_addr` equals the input address. `in_kind` = 0 is a data access.
- R8: In a masked mode, `out_addr` keeps bit 63, fills the tag field with copies of the field's lower boundary bit (47 or 56), and keeps every bit below the field. When `out_fault`=0, the result meets the ordinary rule for the current paging depth.
- R9: `in_ready` = 1 when the output register is empty or `out_ready`=1. A beat is taken when `in_valid` and `in_ready` are both 1 at a clock edge, and its result appears on the next cycle. While `out_valid`=1 and `out_ready`=0, the outputs hold steady.
- R10: When `rst_n` is low, `out_valid` is 0, and it stays 0 after release until a beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_addr | input | 64 | Possibly tagged linear address |
| in_kind | input | 2 | 0 data, 1 fetch, 2 control/model-register write |
| in_u_narrow | input | 1 | User 6-bit tag enable |
| in_u_wide | input | 1 | User 15-bit tag enable |
| in_s_en | input | 1 | Supervisor masking enable |
| in_five_lvl | input | 1 | 1 = five-level paging, 0 = four-level |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Untagged address |
| out_fault | output | 1 | Canonicality violation for this beat |

## Verification
The properties assume the control inputs (`in_u_narrow`, `in_u_wide`, `in_s_en`, `in_five_lvl`) and `in_kind` stay stable while a beat is being accepted. They also assume `in_kind` never takes the value 3. The stimulus only changes these inputs between beats, away from clock edges, and sweeps just the three legal kinds. Every address is built from the bits that decide the rules (63, the tag field, 56, bits 55:48, 47). Each of these is set to all-zero, all-one or mixed values, so all the equal and unequal boundary cases occur.

// File: rtl/untag_pkg.sv
package untag_pkg;
  typedef enum logic [1:0] {
    ACC_DATA  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_CTRL  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MSK_NONE    = 2'd0,
    MSK_WIDE    = 2'd1,
    MSK_NARROW  = 2'd2,
    MSK_U_SHORT = 2'd3
  } msk_mode_e;
endpackage

// File: rtl/untag_mode_sel.sv
module untag_mode_sel
  import untag_pkg::*;
(
  input  logic       sup_ptr,
  input  acc_kind_e  kind,
  input  logic       u_narrow,
  input  logic       u_wide,
  input  logic       s_en,
  input  logic       five_lvl,
  output msk_mode_e  mode
);
  always_comb begin
    mode = MSK_NONE;
    if (kind == ACC_DATA) begin
      if (!sup_ptr) begin
        if (u_narrow)    mode = five_lvl ? MSK_NARROW : MSK_U_SHORT;
        else if (u_wide) mode = MSK_WIDE;
      end else if (s_en) begin
        mode = five_lvl ? MSK_NARROW : MSK_WIDE;
      end
    end
  end
endmodule

// File: rtl/untag_canon_chk.sv
module untag_canon_chk
  import untag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LOW_EDGE  = 47,
  parameter int HIGH_EDGE = 56
) (
  input  logic [ADDR_W-1:0] addr,
  input  msk_mode_e         mode,
  input  logic              five_lvl,
  output logic [ADDR_W-1:0] addr_out,
  output logic              fault
);
  localparam int TOP = ADDR_W - 1;

  logic [ADDR_W-1:0] strip_wide;
  logic [ADDR_W-1:0] strip_narrow;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
      if (gi == TOP) begin : g_top
        assign strip_wide[gi]   = addr[gi];
        assign strip_narrow[gi] = addr[gi];
      end else if (gi > HIGH_EDGE) begin : g_hi
        assign strip_wide[gi]   = addr[LOW_EDGE];
        assign strip_narrow[gi] = addr[HIGH_EDGE];
      end else if (gi > LOW_EDGE) begin : g_mid
        assign strip_wide[gi]   = addr[LOW_EDGE];
        assign strip_narrow[gi] = addr[gi];
      end else begin : g_lo
        assign strip_wide[gi]   = addr[gi];
        assign strip_narrow[gi] = addr[gi];
      end
    end
  endgenerate

  logic shallow_ok, deep_ok, legacy_ok;
  logic wide_ok, narrow_ok, short_ok;

  always_comb begin
    shallow_ok = (&addr[TOP:LOW_EDGE]) | ~(|addr[TOP:LOW_EDGE]);
    deep_ok    = (&addr[TOP:HIGH_EDGE]) | ~(|addr[TOP:HIGH_EDGE]);
    legacy_ok  = five_lvl ? deep_ok : shallow_ok;
    wide_ok    = addr[TOP] == addr[LOW_EDGE];
    narrow_ok  = addr[TOP] == addr[HIGH_EDGE];
    short_ok   = !addr[TOP] && ~(|addr[HIGH_EDGE:LOW_EDGE]);
  end

  always_comb begin
    unique case (mode)
      MSK_WIDE: begin
        addr_out = strip_wide;
        fault    = !wide_ok;
      end
      MSK_NARROW: begin
        addr_out = strip_narrow;
        fault    = !narrow_ok;
      end
      MSK_U_SHORT: begin
        addr_out = strip_narrow;
        fault    = !short_ok;
      end
      default: begin
        addr_out = addr;
        fault    = !legacy_ok;
      end
    endcase
  end
endmodule

// File: rtl/untag_pipe_reg.sv
module untag_pipe_reg #(
  parameter int DATA_W = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              load;

  always_comb begin
    up_ready = !vld_q || dn_ready;
    load     = up_valid && up_ready;
    vld_d    = vld_q;
    dat_d    = dat_q;
    if (load) begin
      vld_d = 1'b1;
      dat_d = up_data;
    end else if (dn_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) dat_q <= dat_d;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/addr_untag_stage.sv
module addr_untag_stage
  import untag_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LOW_EDGE  = 47,
  parameter int HIGH_EDGE = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_kind,
  input  logic              in_u_narrow,
  input  logic              in_u_wide,
  input  logic              in_s_en,
  input  logic              in_five_lvl,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault
);
  localparam int PAY_W = ADDR_W + 1;

  msk_mode_e         mode;
  logic [ADDR_W-1:0] clean_addr;
  logic              bad;
  logic [PAY_W-1:0]  pay_out;

  untag_mode_sel u_sel (
    .sup_ptr  (in_addr[ADDR_W-1]),
    .kind     (acc_kind_e'(in_kind)),
    .u_narrow (in_u_narrow),
    .u_wide   (in_u_wide),
    .s_en     (in_s_en),
    .five_lvl (in_five_lvl),
    .mode     (mode)
  );

  untag_canon_chk #(
    .ADDR_W    (ADDR_W),
    .LOW_EDGE  (LOW_EDGE),
    .HIGH_EDGE (HIGH_EDGE)
  ) u_chk (
    .addr     (in_addr),
    .mode     (mode),
    .five_lvl (in_five_lvl),
    .addr_out (clean_addr),
    .fault    (bad)
  );

  untag_pipe_reg #(
    .DATA_W (PAY_W)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({bad, clean_addr}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign out_fault = pay_out[PAY_W-1];
  assign out_addr  = pay_out[ADDR_W-1:0];
endmodule

// File: rtl/addr_untag_sva.sv
module addr_untag_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_addr,
  input logic [1:0]  in_kind,
  input logic        in_u_narrow,
  input logic        in_u_wide,
  input logic        in_five_lvl,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_addr,
  input logic        out_fault
);
  logic take;
  assign take = in_valid && in_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R10: assert (!out_valid);
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_fault)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault) |-> ((&out_addr[63:56]) || !(|out_addr[63:56])));

  assert_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind != 2'd0 && ((&in_addr[63:47]) || !(|in_addr[63:47])))
    |=> (!out_fault && out_addr == $past(in_addr)));

  assert_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd0 && !in_addr[63] && !in_u_narrow && in_u_wide && in_addr[47])
    |=> out_fault);

  assert_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 2'd0 && !in_addr[63] && in_u_narrow && !in_five_lvl && (|in_addr[56:47]))
    |=> out_fault);
endmodule

bind addr_untag_stage addr_untag_sva chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_addr     (in_addr),
  .in_kind     (in_kind),
  .in_u_narrow (in_u_narrow),
  .in_u_wide   (in_u_wide),
  .in_five_lvl (in_five_lvl),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_fault   (out_fault)
);

// File: tb/addr_untag_stage_tb_top.sv
`timescale 1ns/1ps
module addr_untag_stage_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_addr;
  logic [1:0]  in_kind;
  logic        in_u_narrow, in_u_wide, in_s_en, in_five_lvl;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_addr;
  logic        out_fault;

  int checks;
  int fails;
  bit done;

  addr_untag_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_kind(in_kind), .in_u_narrow(in_u_narrow),
    .in_u_wide(in_u_wide), .in_s_en(in_s_en), .in_five_lvl(in_five_lvl),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_fault(out_fault)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent arithmetic model of the requirements.
  task automatic model(input logic [63:0] a, input logic [1:0] k,
                       input bit un, input bit uw, input bit se, input bit fv,
                       output logic [63:0] e, output bit f, output string tag);
    int bnd;
    logic signed [63:0] sx;
    bnd = -1;
    if (k != 2'd0) tag = "R7";
    else if (!a[63]) begin
      if (un) begin
        bnd = 56; tag = fv ? "R1 R5" : "R1 R6";
      end else if (uw) begin
        bnd = 47; tag = "R1 R4";
      end else tag = "R3";
    end else begin
      if (se) begin
        bnd = fv ? 56 : 47; tag = fv ? "R2 R5" : "R2 R4";
      end else tag = "R3";
    end
    if (bnd < 0) begin
      sx = $signed(a) >>> (fv ? 56 : 47);
      f  = !(sx == 64'sd0 || sx == -64'sd1);
      e  = a;
    end else begin
      sx = $signed(a << (63 - bnd)) >>> (63 - bnd);
      e  = {a[63], sx[62:0]};
      if (k == 2'd0 && !a[63] && un && !fv)
        f = a[63] || (((a >> 47) & 64'h3ff) != 0);
      else
        f = a[63] != a[bnd];
    end
  endtask

  function automatic logic [63:0] mk_addr(int i);
    logic [5:0] meta;
    logic [7:0] mid;
    int r;
    r = i;
    meta = (r % 3 == 0) ? 6'h00 : (r % 3 == 1) ? 6'h3f : 6'h2a; r = r / 3;
    mid  = (r % 3 == 0) ? 8'h00 : (r % 3 == 1) ? 8'hff : 8'h5a; r = r / 3;
    return {r[0], meta, r[1], mid, r[2], 47'h1234_5678_9abc ^ 47'(i * 97)};
  endfunction

  task automatic run_one(input logic [63:0] a, input logic [1:0] k,
                         input bit un, input bit uw, input bit se, input bit fv);
    logic [63:0] e;
    bit f;
    string tag;
    model(a, k, un, uw, se, fv, e, f, tag);
    in_valid = 1'b1; in_addr = a; in_kind = k;
    in_u_narrow = un; in_u_wide = uw; in_s_en = se; in_five_lvl = fv;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R9", "valid after take", 65'(out_valid), 65'd1);
    check(out_addr == e && out_fault == f, tag, "addr/fault",
          {out_fault, out_addr}, {f, e});
    if (!f && k == 2'd0) begin
      logic signed [63:0] s2;
      s2 = $signed(out_addr) >>> (fv ? 56 : 47);
      check(s2 == 64'sd0 || s2 == -64'sd1, "R8", "untagged canonical",
            65'(out_addr), 65'(e));
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] aa, bb;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_addr = '0; in_kind = '0;
    in_u_narrow = 0; in_u_wide = 0; in_s_en = 0; in_five_lvl = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid in reset", 65'(out_valid), 65'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
          {63'd0, out_valid, in_ready}, 65'd1);

    // Full sweep of kinds, control bits and address shapes.
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 72; i++)
          run_one(mk_addr(i), 2'(k), c[0], c[1], c[2], c[3]);

    // Back-pressure: R9
    aa = 64'h8001_2345_6789_abcd; bb = 64'h0000_1111_2222_3333;
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = aa; in_kind = 2'd1;
    in_u_narrow = 0; in_u_wide = 0; in_s_en = 0; in_five_lvl = 0;
    @(negedge clk);
    check(out_valid && !in_ready, "R9", "stalled full", {63'd0, out_valid, in_ready}, 65'd2);
    in_addr = bb;
    repeat (2) @(negedge clk);
    check(out_addr == aa && out_fault == 1'b1, "R9", "hold under stall",
          {out_fault, out_addr}, {1'b1, aa});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_addr == bb && !out_fault, "R9", "next beat after release",
          {out_fault, out_addr}, {1'b0, bb});
    @(negedge clk);
    check(!out_valid, "R9", "drained", 65'(out_valid), 65'd0);

    // Reset while holding a beat: R10
    out_ready = 1'b0; in_valid = 1'b1; in_addr = aa;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!out_valid, "R10", "async clear", 65'(out_valid), 65'd0);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R10", "stays empty", 65'(out_valid), 65'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule